// File: doc/BRIEF.md
# Firing-Variance Readout Pruner

This block watches the spike outputs of a bank of reservoir neurons and decides which of their binary readout connections are worth keeping. Every clock step it receives one spike bit per neuron. A window-end strobe closes the current observation window. For each neuron, the spikes counted in that window are then folded into a running sum and a running sum of squares. A shared counter tracks how many windows have completed.

An evaluate command starts a serial walk over the neurons, one neuron per clock. For each neuron the block forms a division-free variance figure, `n*sumsq - sum*sum`, and compares it against the threshold scaled by `n*n`. A neuron whose firing variance falls strictly below the threshold has its readout-enable bit cleared, which turns that readout path off to save energy. A neuron that never fires has zero variance, so it is pruned in the same way. A cleared bit stays cleared until reset or a clear command. When the last neuron has been judged, the block raises a one-cycle done pulse.

Top module: `spike_var_pruner`

## Requirements
- R1: After reset every bit of `enable_o` is 1, `done_o` is 0, and all per-neuron statistics and the window count are zero.
- R2: On a cycle with `win_end_i` high, the count closed for each neuron includes that cycle's spike bit. A per-window count saturates at 2^CNT_W-1, so with CNT_W=5 a neuron firing on all 40 cycles of a window closes with 31.
- R3: The completed-window count saturates at 2^WIN_W-1 (15 with defaults). Once it is saturated, further window ends add nothing to any sum or sum of squares.
- R4: During a walk, neuron i is pruned exactly when `n*sumsq_i - sum_i^2 < thresh_i*n^2` (strict). With equality the bit is kept, and a threshold of 0 prunes nothing.
- R5: A neuron that has not fired in any of at least one completed window is pruned whenever the threshold is non-zero.
- R6: `enable_o` bits only ever go from 1 to 0, at most one per cycle and only during a walk. A cleared bit is never restored by a later evaluation; only reset or `clear_i` restores it.
- R7: An `eval_i` sampled while idle starts a walk. Neuron i is decided at the (i+1)-th clock edge after that. `done_o` is high for exactly one cycle, seen at the (N_NEUR+1)-th sampling point after the command. `eval_i` during a walk is ignored.
- R8: `clear_i` aborts any walk without a done pulse, sets all of `enable_o` to 1, and zeroes all statistics and the window count.
- R9: An evaluation with no completed windows prunes nothing, whatever the threshold.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spike_i | input | N_NEUR | One spike bit per neuron for this step |
| win_end_i | input | 1 | Closes the current observation window |
| eval_i | input | 1 | Starts a pruning walk when idle |
| clear_i | input | 1 | Restores the reset state synchronously |
| thresh_i | input | THR_W | Variance threshold, unsigned |
| enable_o | output | N_NEUR | Readout-enable mask, bit i for neuron i |
| done_o | output | 1 | One-cycle pulse when a walk completes |

## Verification
The embedded assertions check the following on every cycle:
- mask bits never rise except through clear;
- at most one bit changes per cycle;
- the mask is frozen while idle;
- the done flag is a single-cycle pulse;
- the window count holds once saturated;
- the judged neuron's statistics always give a non-negative spread.

Only the bench's scenarios can show the arithmetic outcome of a walk: which neurons fall on which side of the strict threshold, including the exact-equality boundary. The same holds for count saturation, inclusion of the closing-cycle spike, statistic freezing after the window limit, the abort-by-clear path and the exact latency of the done pulse.

// File: rtl/spv_pkg.sv
package spv_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_e;
endpackage

// File: rtl/spv_win_counter.sv
module spv_win_counter #(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             win_end_i,
    output logic [WIN_W-1:0] nwin_o,
    output logic             close_o
);
    localparam logic [WIN_W-1:0] NWIN_MAX = '1;

    typedef struct packed {
        logic [WIN_W-1:0] nwin;
    } wc_state_t;

    wc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.nwin = '0;
        end else if (win_end_i && (st_q.nwin != NWIN_MAX)) begin
            st_d.nwin = st_q.nwin + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nwin_o  = st_q.nwin;
    assign close_o = win_end_i && (st_q.nwin != NWIN_MAX);

    // R3: once saturated, the window count holds until cleared
    assert_nwin_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nwin == NWIN_MAX && !clear_i) |=> (st_q.nwin == NWIN_MAX));
endmodule

// File: rtl/spv_neuron_stats.sv
module spv_neuron_stats #(
    parameter int CNT_W = 5,
    parameter int WIN_W = 4,
    localparam int SUM_W = CNT_W + WIN_W,
    localparam int SQ_W  = 2 * CNT_W + WIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             spike_i,
    input  logic             win_end_i,
    input  logic             close_i,
    output logic [SUM_W-1:0] sum_o,
    output logic [SQ_W-1:0]  sq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int PROD_W = 2 * CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] sum;
        logic [SQ_W-1:0]  sq;
    } ns_state_t;

    ns_state_t st_d, st_q;
    logic [CNT_W-1:0]  closed;
    logic [PROD_W-1:0] closed_sq;

    always_comb begin
        closed    = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + CNT_W'(spike_i);
        closed_sq = PROD_W'(closed) * PROD_W'(closed);
        st_d      = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (win_end_i) begin
            st_d.cnt = '0;
            if (close_i) begin
                st_d.sum = st_q.sum + SUM_W'(closed);
                st_d.sq  = st_q.sq + SQ_W'(closed_sq);
            end
        end else begin
            st_d.cnt = closed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;
    assign sq_o  = st_q.sq;

    // R2: a window end always restarts the per-window count
    assert_count_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && !clear_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/spv_var_judge.sv
module spv_var_judge #(
    parameter int CNT_W = 5,
    parameter int WIN_W = 4,
    parameter int THR_W = 8,
    localparam int SUM_W = CNT_W + WIN_W,
    localparam int SQ_W  = 2 * CNT_W + WIN_W
) (
    input  logic [WIN_W-1:0] nwin_i,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [SQ_W-1:0]  sq_i,
    input  logic [THR_W-1:0] thresh_i,
    output logic             prune_o
);
    localparam int CMP_W = THR_W + 2 * WIN_W + 2 * CNT_W + 2;

    logic [CMP_W-1:0] n_ext, lhs, rsq, spread, limit;

    always_comb begin
        n_ext  = CMP_W'(nwin_i);
        lhs    = n_ext * CMP_W'(sq_i);
        rsq    = CMP_W'(sum_i) * CMP_W'(sum_i);
        spread = lhs - rsq;
        limit  = CMP_W'(thresh_i) * n_ext * n_ext;
        prune_o = (spread < limit);
    end
endmodule

// File: rtl/spike_var_pruner.sv
module spike_var_pruner
    import spv_pkg::*;
#(
    parameter int N_NEUR = 8,
    parameter int CNT_W  = 5,
    parameter int WIN_W  = 4,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_NEUR-1:0] spike_i,
    input  logic              win_end_i,
    input  logic              eval_i,
    input  logic              clear_i,
    input  logic [THR_W-1:0]  thresh_i,
    output logic [N_NEUR-1:0] enable_o,
    output logic              done_o
);
    localparam int SUM_W = CNT_W + WIN_W;
    localparam int SQ_W  = 2 * CNT_W + WIN_W;
    localparam int IDX_W = (N_NEUR > 1) ? $clog2(N_NEUR) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_NEUR - 1);

    typedef struct packed {
        walk_e             walk;
        logic [IDX_W-1:0]  idx;
        logic [N_NEUR-1:0] mask;
        logic              done;
    } top_state_t;

    localparam top_state_t RESET_ST = '{walk: WALK_IDLE, idx: '0, mask: '1, done: 1'b0};

    top_state_t st_d, st_q;

    logic [WIN_W-1:0]              nwin_w;
    logic                          close_w;
    logic [N_NEUR-1:0][SUM_W-1:0]  sum_all;
    logic [N_NEUR-1:0][SQ_W-1:0]   sq_all;
    logic [SUM_W-1:0]              sum_sel;
    logic [SQ_W-1:0]               sq_sel;
    logic                          prune_w;

    spv_win_counter #(.WIN_W(WIN_W)) u_wincnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .win_end_i (win_end_i),
        .nwin_o    (nwin_w),
        .close_o   (close_w)
    );

    for (genvar g = 0; g < N_NEUR; g++) begin : g_cell
        spv_neuron_stats #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_stats (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear_i),
            .spike_i   (spike_i[g]),
            .win_end_i (win_end_i),
            .close_i   (close_w),
            .sum_o     (sum_all[g]),
            .sq_o      (sq_all[g])
        );
    end

    assign sum_sel = sum_all[st_q.idx];
    assign sq_sel  = sq_all[st_q.idx];

    spv_var_judge #(.CNT_W(CNT_W), .WIN_W(WIN_W), .THR_W(THR_W)) u_judge (
        .nwin_i   (nwin_w),
        .sum_i    (sum_sel),
        .sq_i     (sq_sel),
        .thresh_i (thresh_i),
        .prune_o  (prune_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d = RESET_ST;
        end else if (st_q.walk == WALK_BUSY) begin
            if (prune_w) st_d.mask[st_q.idx] = 1'b0;
            if (st_q.idx == IDX_LAST) begin
                st_d.walk = WALK_IDLE;
                st_d.idx  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (eval_i) begin
            st_d.walk = WALK_BUSY;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.mask;
    assign done_o   = st_q.done;

    // R6: without clear, no bit of the mask can rise
    assert_mask_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((st_q.mask & ~$past(st_q.mask)) == '0));
    // R6: at most one mask bit changes per cycle
    assert_one_bit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ($countones(st_q.mask ^ $past(st_q.mask)) <= 1));
    // R6: idle mask is frozen
    assert_idle_mask_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.walk == WALK_IDLE && !clear_i) |=> $stable(st_q.mask));
    // R7: done is a single-cycle pulse
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    // R4: the statistics of the judged neuron give a non-negative spread
    assert_spread_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.walk == WALK_BUSY) |->
            (64'(nwin_w) * 64'(sq_sel) >= 64'(sum_sel) * 64'(sum_sel)));
endmodule

// File: tb/spike_var_pruner_tb.sv
module spike_var_pruner_tb_top;
    localparam int N    = 8;
    localparam int CW   = 5;
    localparam int WW   = 4;
    localparam int TW   = 8;
    localparam int CMAX = (1 << CW) - 1;
    localparam int NMAX = (1 << WW) - 1;
    localparam int WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  spike_i = '0;
    logic          win_end_i = 1'b0;
    logic          eval_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [TW-1:0] thresh_i = '0;
    logic [N-1:0]  enable_o;
    logic          done_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spike_var_pruner #(.N_NEUR(N), .CNT_W(CW), .WIN_W(WW), .THR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spike_i(spike_i), .win_end_i(win_end_i),
        .eval_i(eval_i), .clear_i(clear_i), .thresh_i(thresh_i),
        .enable_o(enable_o), .done_o(done_o)
    );

    // behavioural reference model
    longint m_cnt [N];
    longint m_sum [N];
    longint m_sq  [N];
    longint m_nwin;
    logic [N-1:0] m_mask;
    bit m_walk, m_done;
    int m_idx;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0; m_sum[i] = 0; m_sq[i] = 0;
        end
        m_nwin = 0; m_mask = '1; m_walk = 0; m_done = 0; m_idx = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n || clear_i) begin
            model_reset();
        end else begin
            m_done = 0;
            if (m_walk) begin
                longint spread, limit;
                spread = m_nwin * m_sq[m_idx] - m_sum[m_idx] * m_sum[m_idx];
                limit  = longint'(thresh_i) * m_nwin * m_nwin;
                if (spread < limit) m_mask[m_idx] = 1'b0;
                if (m_idx == N - 1) begin
                    m_walk = 0; m_idx = 0; m_done = 1;
                end else begin
                    m_idx++;
                end
            end else if (eval_i) begin
                m_walk = 1; m_idx = 0;
            end
            for (int i = 0; i < N; i++) begin
                longint c;
                c = m_cnt[i] + longint'(spike_i[i]);
                if (c > CMAX) c = CMAX;
                if (win_end_i) begin
                    if (m_nwin < NMAX) begin
                        m_sum[i] += c; m_sq[i] += c * c;
                    end
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = c;
                end
            end
            if (win_end_i && m_nwin < NMAX) m_nwin++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(enable_o == m_mask, "R6 mask vs model", enable_o, m_mask);
            chk(done_o == m_done, "R7 done vs model", done_o, m_done);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic bit spk(int ph, int n, int w, int c);
        case (ph)
            1: case (n)
                   1: return 1'b1;
                   2: return (w % 2 == 0);
                   3: return (c < w);
                   4: return (c < 2 * w);
                   5: return (c < w + 1);
                   6: return (w == 0 && c == 0);
                   7: return (w % 2 == 1 && c < 5);
                   default: return 1'b0;
               endcase
            3: return (n == 1);
            4: return (n == 2 && w == 0);
            5: return (n == 3 && c < ((w < 15) ? 2 : 8));
            default: return 1'b0;
        endcase
    endfunction

    task automatic step(input logic [N-1:0] s, input bit we, input bit ev, input bit cl);
        @(negedge clk);
        spike_i = s; win_end_i = we; eval_i = ev; clear_i = cl;
    endtask

    task automatic run_windows(input int ph, input int nw);
        for (int w = 0; w < nw; w++) begin
            int len;
            len = (ph == 3) ? ((w == 0) ? 40 : 31) : ((ph == 5) ? 8 : 10);
            for (int c = 0; c < len; c++) begin
                logic [N-1:0] s;
                for (int n = 0; n < N; n++) s[n] = spk(ph, n, w, c);
                step(s, (c == len - 1), 1'b0, 1'b0);
            end
        end
    endtask

    // returns first step index at which done was seen and how many pulses
    task automatic do_eval(input int thr, input bit extra, output int first, output int pulses);
        thresh_i = TW'(thr);
        step('0, 1'b0, 1'b1, 1'b0);
        first = -1; pulses = 0;
        for (int k = 1; k <= N + 3; k++) begin
            step('0, 1'b0, (extra && k == 3), 1'b0);
            if (done_o) begin
                pulses++;
                if (first < 0) first = k;
            end
        end
    endtask

    initial begin
        int first, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(enable_o == '1, "R1 reset mask", enable_o, 8'hFF);
        chk(done_o == 1'b0, "R1 reset done", done_o, 0);

        // no windows yet
        do_eval(200, 0, first, pulses);
        chk(enable_o == '1, "R9 no windows prunes nothing", enable_o, 8'hFF);

        // phase A: mixed patterns
        step('0, 0, 0, 1);
        run_windows(1, 4);
        do_eval(2, 1, first, pulses);
        chk(first == N + 1, "R7 done latency", first, N + 1);
        chk(pulses == 1, "R7 single done, mid-walk eval ignored", pulses, 1);
        chk(enable_o == 8'h94, "R4 variance pruning pattern", enable_o, 8'h94);
        chk(enable_o[0] == 1'b0, "R5 silent neuron pruned", enable_o[0], 0);
        do_eval(0, 0, first, pulses);
        chk(enable_o == 8'h94, "R6 cleared bits stay cleared", enable_o, 8'h94);

        // clear aborts a walk
        thresh_i = 8'd200;
        step('0, 0, 1, 0);
        step('0, 0, 0, 0);
        step('0, 0, 0, 0);
        step('0, 0, 0, 1);
        pulses = 0;
        for (int k = 0; k < N + 3; k++) begin
            step('0, 0, 0, 0);
            if (done_o) pulses++;
        end
        chk(enable_o == '1, "R8 clear restores mask", enable_o, 8'hFF);
        chk(pulses == 0, "R8 aborted walk has no done", pulses, 0);
        do_eval(5, 0, first, pulses);
        chk(enable_o == '1, "R8 clear zeroed statistics", enable_o, 8'hFF);

        // phase B: strict threshold boundary
        step('0, 0, 0, 1);
        run_windows(1, 2);
        do_eval(0, 0, first, pulses);
        chk(enable_o == '1, "R4 zero threshold prunes nothing", enable_o, 8'hFF);
        do_eval(1, 0, first, pulses);
        chk(enable_o[4] == 1'b1, "R4 equality keeps bit", enable_o[4], 1);
        do_eval(2, 0, first, pulses);
        chk(enable_o[4] == 1'b0, "R4 above-equality prunes bit", enable_o[4], 0);

        // phase C: per-window count saturation
        step('0, 0, 0, 1);
        run_windows(3, 2);
        do_eval(1, 0, first, pulses);
        chk(enable_o[1] == 1'b0, "R2 count saturates", enable_o[1], 0);

        // phase D: closing-cycle spike is counted
        step('0, 0, 0, 1);
        run_windows(4, 2);
        do_eval(21, 0, first, pulses);
        chk(enable_o[2] == 1'b1, "R2 closing spike counted", enable_o[2], 1);

        // phase E: statistics freeze at the window limit
        step('0, 0, 0, 1);
        run_windows(5, 20);
        do_eval(1, 0, first, pulses);
        chk(enable_o[3] == 1'b0, "R3 statistics frozen", enable_o[3], 0);

        step('0, 0, 0, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule